// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 device from power-up to a state where a memory controller can take over, with no software involved. After a start request it releases the device reset with on-die termination enabled and clock enable low, waits, raises clock enable, waits again, and then issues four mode-register loads in the fixed order MR2, MR3, MR1, MR0. A ZQ long calibration follows. When the last wait has elapsed it raises a done flag, which hands the command interface to the controller.

Commands leave on the phase-0 slot of a DFI-style command interface. Each command lasts one clock cycle. Between commands every command strobe sits inactive (high) and bank and address are zero. All wait lengths are given in nanoseconds and converted to clock cycles from a clock-period parameter. This lets a simulation shrink a millisecond-long bring-up to a few dozen cycles. The mode-register values are also parameters.

Top module: `ddr3_bringup_seq`

## Requirements
- R1: While `rst_ni` is low, and afterwards until a start is seen, the outputs are: `dfi_reset_n_o`=0, `dfi_cke_o`=0, `dfi_odt_o`=0, all four command strobes high, bank 0, address 0, and `done_o`=0.
- R2: `start_i` high at a clock edge in the idle state drives `dfi_reset_n_o` and `dfi_odt_o` high from the next cycle. `dfi_cke_o` stays low for exactly PRE cycles, where PRE = ceil(PWR_WAIT_NS*1000/CLK_PS), with a minimum of 1. `dfi_cke_o` is never high while `dfi_reset_n_o` is low.
- R3: `dfi_cke_o` then rises and stays high for POST = ceil(CKE_WAIT_NS*1000/CLK_PS) cycles before the first command. It remains high until reset.
- R4: Four mode-register loads follow in this order: bank 2 with MR2_VAL (default 0x200), bank 3 with MR3_VAL (0x000), bank 1 with MR1_VAL (0x006), and bank 0 with MR0_VAL (0x320). Each load holds {cs_n,ras_n,cas_n,we_n}=4'b0000 for exactly one cycle.
- R5: After each of the first three loads there are exactly TMRD_CYC idle cycles before the next command. An idle cycle has all four strobes at 1, bank 0 and address 0.
- R6: After MR0 there are ceil(MOD_WAIT_NS*1000/CLK_PS) idle cycles. Then a ZQ long calibration is issued for one cycle: address 0x400 (only A10 set), bank 0, {cs_n,ras_n,cas_n,we_n}=4'b0110.
- R7: After the calibration there are ceil(ZQ_WAIT_NS*1000/CLK_PS) idle cycles. Then `done_o` rises, with reset, clock enable and termination held high and the strobes idle.
- R8: `done_o` stays high until reset. Any `start_i` activity during the sequence or after done has no effect on any output.
- R9: Asserting `rst_ni` at any point of the sequence returns the outputs to the R1 state at once. A later start replays the whole sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins the bring-up when idle |
| dfi_reset_n_o | output | 1 | Device reset, active low |
| dfi_cke_o | output | 1 | Clock enable |
| dfi_odt_o | output | 1 | On-die termination enable |
| dfi_cs_n_o | output | 1 | Chip select strobe, active low |
| dfi_ras_n_o | output | 1 | Row strobe, active low |
| dfi_cas_n_o | output | 1 | Column strobe, active low |
| dfi_we_n_o | output | 1 | Write-enable strobe, active low |
| dfi_bank_o | output | BA_W | Bank address of the current command |
| dfi_address_o | output | ADDR_W | Address of the current command |
| done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
The bench compares every output on every cycle against an arithmetic model of the schedule, so each wait is checked to the exact cycle. A counter that loads one value too many or too few shows up as a command one cycle early or late. The bench holds and pulses start during the run and after done, which exposes a design that restarts or re-arms its counters. It also aborts the sequence with reset at every cycle position and then checks for the quiet state. A design that kept clock enable, a stale command or done through reset would fail that check.

// File: rtl/ddr3_bringup_pkg.sv
package ddr3_bringup_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_POST,
        PH_GAP,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        CK_NOP,
        CK_MRS,
        CK_ZQCL
    } cmd_kind_e;

    // index of the final command (ZQ long calibration)
    localparam logic [2:0] LAST_STEP = 3'd4;
    localparam logic [2:0] FIRST_STEP = 3'd0;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int ns_to_cyc(input longint ns, input longint clk_ps);
        longint c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // {cs_n, ras_n, cas_n, we_n}
    function automatic logic [3:0] strobes(input cmd_kind_e k);
        logic [3:0] s;
        case (k)
            CK_MRS:  s = 4'b0000;
            CK_ZQCL: s = 4'b0110;
            default: s = 4'b1111;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ddr3_bringup_timer.sv
module ddr3_bringup_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ddr3_bringup_steps.sv
module ddr3_bringup_steps
    import ddr3_bringup_pkg::*;
#(
    parameter int                ADDR_W    = 14,
    parameter int                BA_W      = 3,
    parameter int                CNT_W     = 8,
    parameter logic [ADDR_W-1:0] MR0_VAL   = 'h320,
    parameter logic [ADDR_W-1:0] MR1_VAL   = 'h006,
    parameter logic [ADDR_W-1:0] MR2_VAL   = 'h200,
    parameter logic [ADDR_W-1:0] MR3_VAL   = 'h000,
    parameter int                TMRD_CYC  = 4,
    parameter int                MOD_CYC   = 500,
    parameter int                ZQ_CYC    = 500
) (
    input  logic [2:0]        idx_i,
    output cmd_kind_e         kind_o,
    output logic [BA_W-1:0]   bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  gap_o
);

    localparam logic [ADDR_W-1:0] ZQ_ADDR = ADDR_W'(1) << 10;

    always_comb begin
        kind_o = CK_NOP;
        bank_o = '0;
        addr_o = '0;
        gap_o  = CNT_W'(TMRD_CYC);
        case (idx_i)
            3'd0: begin
                kind_o = CK_MRS;
                bank_o = BA_W'(2);
                addr_o = MR2_VAL;
            end
            3'd1: begin
                kind_o = CK_MRS;
                bank_o = BA_W'(3);
                addr_o = MR3_VAL;
            end
            3'd2: begin
                kind_o = CK_MRS;
                bank_o = BA_W'(1);
                addr_o = MR1_VAL;
            end
            3'd3: begin
                kind_o = CK_MRS;
                bank_o = BA_W'(0);
                addr_o = MR0_VAL;
                gap_o  = CNT_W'(MOD_CYC);
            end
            3'd4: begin
                kind_o = CK_ZQCL;
                bank_o = BA_W'(0);
                addr_o = ZQ_ADDR;
                gap_o  = CNT_W'(ZQ_CYC);
            end
            default: begin
                kind_o = CK_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr3_bringup_seq.sv
module ddr3_bringup_seq
    import ddr3_bringup_pkg::*;
#(
    parameter int CLK_PS      = 4000,
    parameter int PWR_WAIT_NS = 500000,
    parameter int CKE_WAIT_NS = 500000,
    parameter int MOD_WAIT_NS = 2000,
    parameter int ZQ_WAIT_NS  = 2000,
    parameter int TMRD_CYC    = 4,
    parameter int ADDR_W      = 14,
    parameter int BA_W        = 3,
    parameter logic [ADDR_W-1:0] MR0_VAL = 'h320,
    parameter logic [ADDR_W-1:0] MR1_VAL = 'h006,
    parameter logic [ADDR_W-1:0] MR2_VAL = 'h200,
    parameter logic [ADDR_W-1:0] MR3_VAL = 'h000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              dfi_reset_n_o,
    output logic              dfi_cke_o,
    output logic              dfi_odt_o,
    output logic              dfi_cs_n_o,
    output logic              dfi_ras_n_o,
    output logic              dfi_cas_n_o,
    output logic              dfi_we_n_o,
    output logic [BA_W-1:0]   dfi_bank_o,
    output logic [ADDR_W-1:0] dfi_address_o,
    output logic              done_o
);

    localparam int PRE_CYC  = ns_to_cyc(PWR_WAIT_NS, CLK_PS);
    localparam int POST_CYC = ns_to_cyc(CKE_WAIT_NS, CLK_PS);
    localparam int MOD_CYC  = ns_to_cyc(MOD_WAIT_NS, CLK_PS);
    localparam int ZQ_CYC   = ns_to_cyc(ZQ_WAIT_NS, CLK_PS);
    localparam int GAP_MIN  = (TMRD_CYC < 1) ? 1 : TMRD_CYC;
    localparam int MAX_CYC  = max2(max2(PRE_CYC, POST_CYC),
                                   max2(max2(MOD_CYC, ZQ_CYC), GAP_MIN));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        step;
        logic              rst_n;
        logic              cke;
        logic              odt;
        logic [3:0]        strb;   // {cs_n, ras_n, cas_n, we_n}
        logic [BA_W-1:0]   bank;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_state_t;

    localparam seq_state_t RESET_STATE = '{
        phase: PH_IDLE,
        step:  3'd0,
        rst_n: 1'b0,
        cke:   1'b0,
        odt:   1'b0,
        strb:  4'b1111,
        bank:  '0,
        addr:  '0,
        done:  1'b0
    };

    seq_state_t st_d, st_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    logic [2:0]        issue_idx;
    cmd_kind_e         issue_kind;
    logic [BA_W-1:0]   issue_bank;
    logic [ADDR_W-1:0] issue_addr;
    logic [CNT_W-1:0]  issue_gap;

    // next command: the first one when leaving the clock-enable wait
    assign issue_idx = (st_q.phase == PH_POST) ? FIRST_STEP : 3'(st_q.step + 3'd1);

    ddr3_bringup_steps #(
        .ADDR_W   (ADDR_W),
        .BA_W     (BA_W),
        .CNT_W    (CNT_W),
        .MR0_VAL  (MR0_VAL),
        .MR1_VAL  (MR1_VAL),
        .MR2_VAL  (MR2_VAL),
        .MR3_VAL  (MR3_VAL),
        .TMRD_CYC (GAP_MIN),
        .MOD_CYC  (MOD_CYC),
        .ZQ_CYC   (ZQ_CYC)
    ) u_steps (
        .idx_i  (issue_idx),
        .kind_o (issue_kind),
        .bank_o (issue_bank),
        .addr_o (issue_addr),
        .gap_o  (issue_gap)
    );

    ddr3_bringup_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        // idle command unless a step below issues one
        st_d.strb = 4'b1111;
        st_d.bank = '0;
        st_d.addr = '0;

        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_PRE;
                    st_d.rst_n = 1'b1;
                    st_d.odt   = 1'b1;
                    st_d.cke   = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(PRE_CYC - 1);
                end
            end
            PH_PRE: begin
                if (tmr_expired) begin
                    st_d.phase = PH_POST;
                    st_d.cke   = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(POST_CYC - 1);
                end
            end
            PH_POST, PH_GAP: begin
                if (tmr_expired) begin
                    if (st_q.phase == PH_GAP && st_q.step == LAST_STEP) begin
                        st_d.phase = PH_DONE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.phase = PH_GAP;
                        st_d.step  = issue_idx;
                        st_d.strb  = strobes(issue_kind);
                        st_d.bank  = issue_bank;
                        st_d.addr  = issue_addr;
                        tmr_load   = 1'b1;
                        // command cycle plus the idle gap that follows it
                        tmr_val    = issue_gap;
                    end
                end
            end
            PH_DONE: begin
                st_d.done = 1'b1;
            end
            default: begin
                st_d = RESET_STATE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign dfi_reset_n_o = st_q.rst_n;
    assign dfi_cke_o     = st_q.cke;
    assign dfi_odt_o     = st_q.odt;
    assign dfi_cs_n_o    = st_q.strb[3];
    assign dfi_ras_n_o   = st_q.strb[2];
    assign dfi_cas_n_o   = st_q.strb[1];
    assign dfi_we_n_o    = st_q.strb[0];
    assign dfi_bank_o    = st_q.bank;
    assign dfi_address_o = st_q.addr;
    assign done_o        = st_q.done;

endmodule

// File: rtl/ddr3_bringup_chk.sv
module ddr3_bringup_chk #(
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              dfi_reset_n_o,
    input logic              dfi_cke_o,
    input logic              dfi_odt_o,
    input logic              dfi_cs_n_o,
    input logic              dfi_ras_n_o,
    input logic              dfi_cas_n_o,
    input logic              dfi_we_n_o,
    input logic [BA_W-1:0]   dfi_bank_o,
    input logic [ADDR_W-1:0] dfi_address_o,
    input logic              done_o
);

    localparam logic [ADDR_W-1:0] ZQ_ADDR = ADDR_W'(1) << 10;

    AST_CKE_UNDER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dfi_cke_o |-> dfi_reset_n_o); // R2

    AST_CKE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dfi_cke_o |=> dfi_cke_o); // R3

    AST_CMD_NEEDS_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dfi_cs_n_o |-> (dfi_cke_o && dfi_reset_n_o && dfi_odt_o)); // R4

    AST_CMD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dfi_cs_n_o |=> (dfi_cs_n_o && dfi_bank_o == '0 && dfi_address_o == '0)); // R5

    AST_ZQ_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dfi_cs_n_o && dfi_ras_n_o) |->
            (dfi_cas_n_o && !dfi_we_n_o && dfi_address_o == ZQ_ADDR && dfi_bank_o == '0)); // R6

    AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (dfi_cs_n_o && dfi_cke_o && dfi_odt_o && dfi_reset_n_o)); // R7

    AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> done_o); // R8

endmodule

bind ddr3_bringup_seq ddr3_bringup_chk #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dfi_reset_n_o (dfi_reset_n_o),
    .dfi_cke_o     (dfi_cke_o),
    .dfi_odt_o     (dfi_odt_o),
    .dfi_cs_n_o    (dfi_cs_n_o),
    .dfi_ras_n_o   (dfi_ras_n_o),
    .dfi_cas_n_o   (dfi_cas_n_o),
    .dfi_we_n_o    (dfi_we_n_o),
    .dfi_bank_o    (dfi_bank_o),
    .dfi_address_o (dfi_address_o),
    .done_o        (done_o)
);

// File: tb/ddr3_bringup_seq_bench.sv
`timescale 1ns/1ps
module ddr3_bringup_seq_bench;

    localparam int CLK_PS  = 4000;
    localparam int PWR_NS  = 40;   // 10 cycles
    localparam int CKE_NS  = 30;   // 7.5 -> 8 cycles
    localparam int MOD_NS  = 20;   // 5 cycles
    localparam int ZQ_NS   = 22;   // 5.5 -> 6 cycles
    localparam int TMRD    = 3;
    localparam int ADDR_W  = 14;
    localparam int BA_W    = 3;
    localparam int PW      = ADDR_W + BA_W + 8;

    localparam int PRE   = (PWR_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int POST  = (CKE_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int MODW  = (MOD_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int ZQW   = (ZQ_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int TOTAL = PRE + POST + 3 * (1 + TMRD) + (1 + MODW) + (1 + ZQW);

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic start_i = 1'b0;
    logic dfi_reset_n_o, dfi_cke_o, dfi_odt_o;
    logic dfi_cs_n_o, dfi_ras_n_o, dfi_cas_n_o, dfi_we_n_o;
    logic [BA_W-1:0] dfi_bank_o;
    logic [ADDR_W-1:0] dfi_address_o;
    logic done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ddr3_bringup_seq #(
        .CLK_PS      (CLK_PS),
        .PWR_WAIT_NS (PWR_NS),
        .CKE_WAIT_NS (CKE_NS),
        .MOD_WAIT_NS (MOD_NS),
        .ZQ_WAIT_NS  (ZQ_NS),
        .TMRD_CYC    (TMRD),
        .ADDR_W      (ADDR_W),
        .BA_W        (BA_W)
    ) u_ddr3_bringup_seq (
        .clk_i         (clk),
        .rst_ni        (rst_ni),
        .start_i       (start_i),
        .dfi_reset_n_o (dfi_reset_n_o),
        .dfi_cke_o     (dfi_cke_o),
        .dfi_odt_o     (dfi_odt_o),
        .dfi_cs_n_o    (dfi_cs_n_o),
        .dfi_ras_n_o   (dfi_ras_n_o),
        .dfi_cas_n_o   (dfi_cas_n_o),
        .dfi_we_n_o    (dfi_we_n_o),
        .dfi_bank_o    (dfi_bank_o),
        .dfi_address_o (dfi_address_o),
        .done_o        (done_o)
    );

    function automatic logic [PW-1:0] pack(input logic rn, input logic ck, input logic od,
                                           input logic [3:0] s, input int ba, input int ad,
                                           input logic dn);
        return {rn, ck, od, s, BA_W'(ba), ADDR_W'(ad), dn};
    endfunction

    // expected pins in cycle c after the start edge (c <= 0: idle)
    function automatic logic [PW-1:0] expect_at(input int c, output string tag);
        int t;
        int gap;
        int banks [5];
        int addrs [5];
        banks = '{2, 3, 1, 0, 0};
        addrs = '{'h200, 'h000, 'h006, 'h320, 'h400};
        if (c <= 0) begin
            tag = "R1";
            return pack(1'b0, 1'b0, 1'b0, 4'b1111, 0, 0, 1'b0);
        end
        if (c <= PRE) begin
            tag = "R2";
            return pack(1'b1, 1'b0, 1'b1, 4'b1111, 0, 0, 1'b0);
        end
        if (c <= PRE + POST) begin
            tag = "R3";
            return pack(1'b1, 1'b1, 1'b1, 4'b1111, 0, 0, 1'b0);
        end
        t = PRE + POST + 1;
        for (int k = 0; k < 5; k++) begin
            gap = (k < 3) ? TMRD : ((k == 3) ? MODW : ZQW);
            if (c == t) begin
                tag = (k < 4) ? "R4" : "R6";
                return pack(1'b1, 1'b1, 1'b1, (k < 4) ? 4'b0000 : 4'b0110,
                            banks[k], addrs[k], 1'b0);
            end
            if (c < t + 1 + gap) begin
                tag = (k < 3) ? "R5" : ((k == 3) ? "R6" : "R7");
                return pack(1'b1, 1'b1, 1'b1, 4'b1111, 0, 0, 1'b0);
            end
            t = t + 1 + gap;
        end
        tag = "R7";
        return pack(1'b1, 1'b1, 1'b1, 4'b1111, 0, 0, 1'b1);
    endfunction

    task automatic check_at(input int c, input string extra);
        logic [PW-1:0] act;
        logic [PW-1:0] exp;
        string tag;
        exp = expect_at(c, tag);
        act = {dfi_reset_n_o, dfi_cke_o, dfi_odt_o,
               {dfi_cs_n_o, dfi_ras_n_o, dfi_cas_n_o, dfi_we_n_o},
               dfi_bank_o, dfi_address_o, done_o};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s%s cycle %0d: actual %h expected %h", tag, extra, c, act, exp);
        end
    endtask

    // start at the next edge and compare n cycles; mode 1 keeps poking start (R8)
    task automatic run_seq(input int n, input int mode);
        @(negedge clk);
        check_at(0, "");
        start_i = 1'b1;
        @(posedge clk);
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            check_at(c, (mode == 1) ? "/R8" : "");
            start_i = (mode == 1) ? ((c % 3) != 0) : 1'b0;
        end
        start_i = 1'b0;
    endtask

    // R9: reset forces the idle pins at once and keeps them until a start
    task automatic reset_and_check();
        rst_ni = 1'b0;
        #1;
        check_at(0, "/R9");
        @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        check_at(0, "/R9");
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state and idle without start
        repeat (3) @(negedge clk);
        check_at(0, "");
        rst_ni = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_at(0, "");
        end

        // full sequence with a single start pulse, past done
        run_seq(TOTAL + 6, 0);

        // R8: start kept toggling during and after the sequence
        reset_and_check();
        run_seq(TOTAL + 8, 1);

        // R9: abort at every cycle position, then replay from scratch
        for (int a = 1; a <= TOTAL + 2; a++) begin
            reset_and_check();
            run_seq(a, 0);
        end
        reset_and_check();
        run_seq(TOTAL + 3, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule